// File: doc/BRIEF.md
# Gated Edge-Triggered One-Shot Pulse Generator

This block is a clocked monostable. It has two trigger inputs. The fall input starts a pulse on its high-to-low edge, but only while the rise input is high. The rise input starts a pulse on its low-to-high edge, but only while the fall input is low. The pulse length is a count of clock cycles. It is taken from `widthIn` in the cycle the pulse starts and kept for the rest of the pulse.

A pulse runs to its end. Edges that arrive during a pulse neither extend it nor restart it.

An active-low clear input stops a running pulse and holds the block idle for as long as it stays low. Releasing the clear can also fire a pulse. For that, the trigger inputs must have left the firing combination while clear was low, and must stand at fall-input low and rise-input high when clear is released.

All three control inputs pass through two-flop synchronizers before any decision is made. The output pair is the pulse and its complement.

Top module: `pulse_gen`

## Requirements
- R1: After the system reset, `pulseOut` is 0 and `pulseOutN` is 1, whatever the input levels.
- R2: `pulseOutN` is the inverse of `pulseOut` in every cycle.
- R3: A fall of `trigFallIn` while `trigRiseIn` and `clearN` are high makes `pulseOut` go high after the third rising clock edge that follows the input change. It stays high for exactly `widthIn` cycles.
- R4: A fall of `trigFallIn` while `trigRiseIn` is low produces no pulse.
- R5: A rise of `trigRiseIn` while `trigFallIn` is low and `clearN` is high produces a pulse with the R3 timing. A rise while `trigFallIn` is high produces none.
- R6: Trigger edges that arrive during a pulse do not lengthen it or restart it.
- R7: When `clearN` goes low during a pulse, `pulseOut` is 0 and `pulseOutN` is 1 after the third rising clock edge that follows the change.
- R8: While `clearN` is low, trigger edges produce no pulse.
- R9: A rise of `clearN` produces a pulse with R3 timing in one case: the inputs showed `trigFallIn` high or `trigRiseIn` low at some point while `clearN` was low, and they stand at `trigFallIn` low and `trigRiseIn` high at release.
- R10: A rise of `clearN` produces no pulse if the inputs stayed at `trigFallIn` low and `trigRiseIn` high for the whole time `clearN` was low.
- R11: The width is captured when the pulse starts. Changing `widthIn` during a pulse does not change its length.
- R12: A trigger that arrives with `widthIn` equal to 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| trigFallIn | input | 1 | Trigger on its falling edge, enabled while trigRiseIn is high |
| trigRiseIn | input | 1 | Trigger on its rising edge, enabled while trigFallIn is low |
| clearN | input | 1 | Active-low clear; ends a pulse and blocks triggers |
| widthIn | input | WIDTH_BITS | Pulse length in clock cycles |
| pulseOut | output | 1 | Pulse output, high while a pulse runs |
| pulseOutN | output | 1 | Inverse of pulseOut |

## Verification
A wrong down-counter value shows up as a pulse whose length differs from the captured width. It is visible at the falling edge of `pulseOut` in the same pulse. A stale copy of the synchronized inputs can do two things: fire a pulse on a level that only looks like an edge, or miss a real edge. Either way the error reaches `pulseOut` three edges after the input change, or no pulse appears in that window.

A wrongly kept or wrongly dropped arm flag shows only at the next release of `clearN`, as an extra or missing pulse. The release tests therefore set up both the armed and the unarmed histories.

// File: rtl/pulse_gen_pkg.sv
`timescale 1ns/1ps
package pulse_gen_pkg;
  // Strobes from control to datapath; clear wins over load.
  typedef struct packed {
    logic load;
    logic clear;
  } ctl_strobe_t;
endpackage

// File: rtl/pg_sync.sv
`timescale 1ns/1ps
module pg_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [LAST:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[LAST-1:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[LAST];
  end
endmodule

// File: rtl/pg_ctrl.sv
`timescale 1ns/1ps
module pg_ctrl
  import pulse_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        curFall,
  input  logic        curRise,
  input  logic        curClr,
  input  logic        busy,
  output ctl_strobe_t strobes
);
  logic prevFall, prevRise, prevClr, armed;
  logic clrSteady, fallHit, riseHit, releaseHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFall <= 1'b0;
      prevRise <= 1'b0;
      prevClr  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      prevFall <= curFall;
      prevRise <= curRise;
      prevClr  <= curClr;
      // Arm the release path once inputs leave the firing combination
      if (curClr)                 armed <= 1'b0;
      else if (curFall | ~curRise) armed <= 1'b1;
    end
  end

  always_comb begin
    clrSteady  = curClr & prevClr;
    fallHit    = prevFall & ~curFall & curRise & clrSteady;
    riseHit    = ~prevRise & curRise & ~curFall & clrSteady;
    releaseHit = curClr & ~prevClr & armed & ~curFall & curRise;
    strobes.clear = ~curClr;
    strobes.load  = curClr & ~busy & (fallHit | riseHit | releaseHit);
  end
endmodule

// File: rtl/pg_datapath.sv
`timescale 1ns/1ps
module pg_datapath
  import pulse_gen_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobe_t           strobes,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  busy,
  output logic                  qOut,
  output logic                  qOutN
);
  localparam logic [WIDTH_BITS-1:0] ONE = WIDTH_BITS'(1);

  logic [WIDTH_BITS-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      qOut   <= 1'b0;
      qOutN  <= 1'b1;
    end else if (strobes.clear) begin
      remain <= '0;
      qOut   <= 1'b0;
      qOutN  <= 1'b1;
    end else if (strobes.load) begin
      remain <= widthIn;
      qOut   <= |widthIn;
      qOutN  <= ~|widthIn;
    end else if (qOut) begin
      if (remain == ONE) begin
        remain <= '0;
        qOut   <= 1'b0;
        qOutN  <= 1'b1;
      end else begin
        remain <= remain - ONE;
      end
    end
  end

  assign busy = qOut;
endmodule

// File: rtl/pulse_gen.sv
`timescale 1ns/1ps
module pulse_gen
  import pulse_gen_pkg::*;
#(
  parameter int WIDTH_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigFallIn,
  input  logic                  trigRiseIn,
  input  logic                  clearN,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  pulseOut,
  output logic                  pulseOutN
);
  logic [2:0]  syncVec;
  logic        busy;
  ctl_strobe_t strobes;

  pg_sync #(.N(3), .STAGES(2)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({clearN, trigRiseIn, trigFallIn}),
    .syncOut(syncVec)
  );

  pg_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .curFall(syncVec[0]),
    .curRise(syncVec[1]),
    .curClr (syncVec[2]),
    .busy   (busy),
    .strobes(strobes)
  );

  pg_datapath #(.WIDTH_BITS(WIDTH_BITS)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .widthIn(widthIn),
    .busy   (busy),
    .qOut   (pulseOut),
    .qOutN  (pulseOutN)
  );
endmodule

// File: rtl/pulse_gen_chk.sv
`timescale 1ns/1ps
module pulse_gen_chk #(
  parameter int WIDTH_BITS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clearN,
  input logic [WIDTH_BITS-1:0] widthIn,
  input logic                  pulseOut,
  input logic                  pulseOutN
);
  logic [WIDTH_BITS-1:0] capWidth;
  logic [WIDTH_BITS:0]   runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWidth <= '0;
      runLen   <= '0;
    end else begin
      if (!pulseOut) capWidth <= widthIn;
      runLen <= pulseOut ? runLen + 1'b1 : '0;
    end
  end

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    pulseOutN == !pulseOut); // R2

  AST_CLEAR_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clearN) && !$past(clearN, 2) && !$past(clearN, 3)) |-> !pulseOut); // R7

  AST_NO_START_IN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> $past(clearN, 3)); // R8

  AST_ZERO_WIDTH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> ($past(widthIn) != '0)); // R12

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> (runLen < {1'b0, capWidth})); // R6
endmodule

bind pulse_gen pulse_gen_chk #(.WIDTH_BITS(WIDTH_BITS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .clearN   (clearN),
  .widthIn  (widthIn),
  .pulseOut (pulseOut),
  .pulseOutN(pulseOutN)
);

// File: tb/pulse_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_gen_tb_top;
  localparam int WB = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigFallIn = 1'b1;
  logic          trigRiseIn = 1'b0;
  logic          clearN = 1'b1;
  logic [WB-1:0] widthIn = 8'd5;
  logic          pulseOut, pulseOutN;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pulse_gen #(.WIDTH_BITS(WB)) dut_i (
    .clk(clk), .rstN(rstN), .trigFallIn(trigFallIn), .trigRiseIn(trigRiseIn),
    .clearN(clearN), .widthIn(widthIn), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Samples n negedges; returns index of first high sample and high count.
  task automatic observe(input int n, output int first, output int cnt);
    first = 0;
    cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (pulseOut && first == 0) first = i;
      if (pulseOut) cnt++;
      if (pulseOutN !== ~pulseOut) begin
        checks++;
        errors++;
        $display("FAIL R2 actual=%0d expected=%0d", pulseOutN, ~pulseOut);
      end
    end
  endtask

  task automatic expectPulse(input int w, input string req);
    int first, cnt;
    observe(w + 6, first, cnt);
    check(first == 3, {req, " start"}, first, 3);
    check(cnt == w, {req, " width"}, cnt, w);
  endtask

  task automatic expectNone(input string req);
    int first, cnt;
    observe(12, first, cnt);
    check(cnt == 0, req, cnt, 0);
  endtask

  task automatic testReset;
    idle(1);
    check(pulseOut == 1'b0, "R1 q", pulseOut, 0);
    check(pulseOutN == 1'b1, "R1 qN", pulseOutN, 1);
    check(pulseOutN == ~pulseOut, "R2 reset", pulseOutN, ~pulseOut);
  endtask

  task automatic testFallEdge;
    @(negedge clk); trigRiseIn = 1'b1;     // rise while fall input high
    expectNone("R5 blocked by high fall input");
    widthIn = 8'd5;
    @(negedge clk); trigFallIn = 1'b0;
    expectPulse(5, "R3");
    @(negedge clk); trigFallIn = 1'b1; idle(4);
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  task automatic testFallGated;
    @(negedge clk); trigFallIn = 1'b0;     // rise input low
    expectNone("R4");
  endtask

  task automatic testRiseEdge;
    widthIn = 8'd4;
    @(negedge clk); trigRiseIn = 1'b1;
    expectPulse(4, "R5");
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  task automatic testNoRetrigger;
    int first, cnt;
    widthIn = 8'd8;
    @(negedge clk); trigRiseIn = 1'b1;
    fork
      observe(16, first, cnt);
      begin
        idle(4); trigRiseIn = 1'b0;
        idle(2); trigRiseIn = 1'b1;
      end
    join
    check(first == 3, "R6 start", first, 3);
    check(cnt == 8, "R6 width", cnt, 8);
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  task automatic testWidthLatch;
    int first, cnt;
    widthIn = 8'd6;
    @(negedge clk); trigRiseIn = 1'b1;
    fork
      observe(14, first, cnt);
      begin idle(4); widthIn = 8'd2; end
    join
    check(cnt == 6, "R11 width", cnt, 6);
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  task automatic testZeroWidth;
    widthIn = 8'd0;
    @(negedge clk); trigRiseIn = 1'b1;
    expectNone("R12");
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  task automatic testClearArmed;
    widthIn = 8'd20;
    @(negedge clk); trigRiseIn = 1'b1;
    idle(5);
    check(pulseOut == 1'b1, "R7 running", pulseOut, 1);
    clearN = 1'b0;
    idle(3);
    check(pulseOut == 1'b0, "R7 q", pulseOut, 0);
    check(pulseOutN == 1'b1, "R7 qN", pulseOutN, 1);
    trigRiseIn = 1'b0; idle(4);            // arms the release path
    @(negedge clk); trigRiseIn = 1'b1;
    expectNone("R8");
    widthIn = 8'd7;
    @(negedge clk); clearN = 1'b1;
    expectPulse(7, "R9");
  endtask

  task automatic testClearUnarmed;
    // inputs already fall low / rise high; leave them there through clear
    idle(4);
    @(negedge clk); clearN = 1'b0; idle(6);
    @(negedge clk); clearN = 1'b1;
    expectNone("R10");
    @(negedge clk); trigRiseIn = 1'b0; idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(4);
    testReset();
    testFallEdge();
    testFallGated();
    testRiseEdge();
    testNoRetrigger();
    testWidthLatch();
    testZeroWidth();
    testClearArmed();
    testClearUnarmed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule